// File: doc/BRIEF.md
# Next-PC Address Logic

This block is the combinational next-address unit of a 32-bit processor whose instructions are word aligned. All its arithmetic is done on the 30-bit word address, which is the byte address without its two low bits. From the current word address it works out the address of the following instruction. That address is one of four: the sequential address, a pc-relative branch target, a region-relative jump target, or an address taken from a register. It can also be a fixed trap entry address that is used for system calls.

A single adder produces both the sequential and the branch address. Its carry-in is tied to 1. Its second operand is either zero or the sign-extended 16-bit branch offset, and an inline checker of the branch condition picks between the two. A four-way source select then gives the final next address. The adder result is also driven out as its own output, so the control path can write it to the link register on jump-and-link.

Top module: `npc_next_addr`

## Requirements
- R1: Every address is a 30-bit word address, and all sums wrap modulo 2^30. For example, word address 30'h3FFF_FFFF plus one gives 0.
- R2: With branch type 2'b00 (no branch), `incr_pc_o` equals `pc_word_i + 1` for any register values.
- R3: With branch type 2'b01 (equal), the branch is taken exactly when `rs_val_i == rt_val_i`.
- R4: With branch type 2'b10 (not equal), the branch is taken exactly when `rs_val_i != rt_val_i`.
- R5: With branch type 2'b11 (negative), the branch is taken exactly when `rs_val_i[31]` is 1. `rt_val_i` has no effect in this mode.
- R6: A taken branch gives `incr_pc_o = pc_word_i + 1 + sext(ofs_i)`, and a not-taken branch gives `pc_word_i + 1`. A negative offset moves the address backward.
- R7: With source select 2'b00, `next_pc_o` equals `incr_pc_o`.
- R8: With source select 2'b01, `next_pc_o` is `{pc_word_i[29:26], jta_i}`.
- R9: With source select 2'b10, `next_pc_o` is `rs_val_i[31:2]`. `rs_val_i[1:0]` has no effect.
- R10: With source select 2'b11, `next_pc_o` equals the parameter `TRAP_WADDR` (default 30'h0000_0060).
- R11: `incr_pc_o` does not depend on the source select, so the link value is still there during a jump.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_word_i | input | 30 | Current word address |
| ofs_i | input | 16 | Signed branch offset, in words |
| jta_i | input | 26 | Jump target field |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| br_type_i | input | 2 | Branch type: 00 none, 01 equal, 10 not equal, 11 negative |
| pc_src_i | input | 2 | Source select: 00 sequential, 01 jump, 10 register, 11 trap |
| next_pc_o | output | 30 | Next word address |
| incr_pc_o | output | 30 | Sequential or branch address, also the link value |

## Verification
The branch condition is tried with each branch type in turn.
- Equal and unequal register pairs show that the equal and not-equal modes have opposite polarity.
- In negative mode, an rs with only bit 31 set is paired with an rt that is equal to it, and a positive rs is paired with an unequal rt. Taken together, these show the mode reads the sign bit and not the comparison.

The adder is tested at the top of the address range and with positive, negative and wrapping offsets. These cases separate a correct sign extension and carry-in from a zero extension or a missing carry-in. Each source select is tried with a non-trivial upper region, with nonzero low bits in rs, and with a branch active at the same time. This shows that each source is routed on its own and that the link output keeps its value.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_EQ   = 2'b01,
    BR_NE   = 2'b10,
    BR_NEG  = 2'b11
  } br_kind_e;

  typedef enum logic [1:0] {
    SRC_SEQ  = 2'b00,
    SRC_JUMP = 2'b01,
    SRC_REG  = 2'b10,
    SRC_TRAP = 2'b11
  } pc_src_e;
endpackage

// File: rtl/npc_branch_check.sv
module npc_branch_check
  import npc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rt_i,
  input  logic [1:0]        kind_i,
  output logic              taken_o
);
  logic same;
  assign same = (rs_i == rt_i);

  always_comb begin
    unique case (br_kind_e'(kind_i))
      BR_EQ:   taken_o = same;
      BR_NE:   taken_o = ~same;
      BR_NEG:  taken_o = rs_i[DATA_W-1];
      default: taken_o = 1'b0;
    endcase
  end

  always_comb begin
    if (kind_i == 2'b00) begin
      AST_NO_BRANCH_IDLE: assert (!taken_o); // R2
    end
    if (kind_i == 2'b01 && taken_o) begin
      AST_EQ_TAKEN_MATCH: assert ((rs_i ^ rt_i) == '0); // R3
    end
    if (kind_i == 2'b10 && taken_o) begin
      AST_NE_TAKEN_DIFF: assert (|(rs_i ^ rt_i)); // R4
    end
    if (kind_i == 2'b11) begin
      AST_NEG_SIGN_ONLY: assert (taken_o == $signed(rs_i) < 0); // R5
    end
  end
endmodule

// File: rtl/npc_incr_adder.sv
module npc_incr_adder #(
  parameter int W = 30
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] addend_i,
  output logic [W-1:0] sum_o
);
  localparam logic [W-1:0] CIN = {{(W-1){1'b0}}, 1'b1};

  // carry-in tied high: base + addend + 1, modulo 2^W
  assign sum_o = base_i + addend_i + CIN;

  always_comb begin
    if (addend_i == '0) begin
      AST_STEP_ONE: assert (sum_o - base_i == CIN); // R1
    end
  end
endmodule

// File: rtl/npc_src_mux.sv
module npc_src_mux
  import npc_pkg::*;
#(
  parameter int                WORD_W     = 30,
  parameter int                JTA_W      = 26,
  parameter logic [WORD_W-1:0] TRAP_WADDR = '0
) (
  input  logic [WORD_W-1:0] seq_i,
  input  logic [WORD_W-1:0] cur_i,
  input  logic [JTA_W-1:0]  jta_i,
  input  logic [WORD_W-1:0] reg_i,
  input  logic [1:0]        sel_i,
  output logic [WORD_W-1:0] next_o
);
  localparam int REGION_W = WORD_W - JTA_W;

  logic [WORD_W-1:0] jump_addr;
  assign jump_addr = {cur_i[WORD_W-1 -: REGION_W], jta_i};

  always_comb begin
    unique case (pc_src_e'(sel_i))
      SRC_JUMP: next_o = jump_addr;
      SRC_REG:  next_o = reg_i;
      SRC_TRAP: next_o = TRAP_WADDR;
      default:  next_o = seq_i;
    endcase
  end

  always_comb begin
    if (sel_i == 2'b01) begin
      AST_JUMP_REGION_KEPT: assert (next_o[WORD_W-1 -: REGION_W] == cur_i[WORD_W-1 -: REGION_W]); // R8
      AST_JUMP_LOW_FIELD: assert (next_o[JTA_W-1:0] == jta_i); // R8
    end
    if (sel_i == 2'b11) begin
      AST_TRAP_FIXED: assert (next_o == TRAP_WADDR); // R10
    end
  end
endmodule

// File: rtl/npc_next_addr.sv
module npc_next_addr
  import npc_pkg::*;
#(
  parameter int                      ADDR_W     = 32,
  parameter int                      OFS_W      = 16,
  parameter int                      JTA_W      = 26,
  parameter logic [ADDR_W-3:0]       TRAP_WADDR = 30'h0000_0060
) (
  input  logic [ADDR_W-3:0] pc_word_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [JTA_W-1:0]  jta_i,
  input  logic [ADDR_W-1:0] rs_val_i,
  input  logic [ADDR_W-1:0] rt_val_i,
  input  logic [1:0]        br_type_i,
  input  logic [1:0]        pc_src_i,
  output logic [ADDR_W-3:0] next_pc_o,
  output logic [ADDR_W-3:0] incr_pc_o
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int EXT_W  = WORD_W - OFS_W;
  localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

  logic              taken;
  logic [WORD_W-1:0] ofs_ext;
  logic [WORD_W-1:0] addend;

  npc_branch_check #(.DATA_W(ADDR_W)) u_cond (
    .rs_i    (rs_val_i),
    .rt_i    (rt_val_i),
    .kind_i  (br_type_i),
    .taken_o (taken)
  );

  assign ofs_ext = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i};
  assign addend  = taken ? ofs_ext : '0;

  npc_incr_adder #(.W(WORD_W)) u_add (
    .base_i   (pc_word_i),
    .addend_i (addend),
    .sum_o    (incr_pc_o)
  );

  npc_src_mux #(
    .WORD_W     (WORD_W),
    .JTA_W      (JTA_W),
    .TRAP_WADDR (TRAP_WADDR)
  ) u_mux (
    .seq_i  (incr_pc_o),
    .cur_i  (pc_word_i),
    .jta_i  (jta_i),
    .reg_i  (rs_val_i[ADDR_W-1:2]),
    .sel_i  (pc_src_i),
    .next_o (next_pc_o)
  );

  always_comb begin
    if (br_type_i == 2'b00) begin
      AST_SEQ_STEP: assert (incr_pc_o == pc_word_i + ONE); // R2
    end
    if (br_type_i == 2'b10 && rs_val_i == rt_val_i) begin
      AST_NE_FALLTHROUGH: assert (incr_pc_o == pc_word_i + ONE); // R4
    end
    if (br_type_i == 2'b01 && rs_val_i == rt_val_i) begin
      AST_EQ_TARGET: assert (incr_pc_o - ONE - pc_word_i == ofs_ext); // R6
    end
    if (pc_src_i == 2'b00) begin
      AST_SEQ_PASS: assert (next_pc_o == incr_pc_o); // R7
    end
    if (pc_src_i == 2'b10) begin
      AST_REG_WORD: assert ({next_pc_o, 2'b00} == {rs_val_i[ADDR_W-1:2], 2'b00}); // R9
    end
  end
endmodule

// File: tb/npc_next_addr_test.sv
`timescale 1ns/1ps
module npc_next_addr_test;
  localparam logic [29:0] TRAP = 30'h0000_0060;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [29:0] pc_word;
  logic [15:0] ofs;
  logic [25:0] jta;
  logic [31:0] rs_val, rt_val;
  logic [1:0]  br_type, pc_src;
  logic [29:0] next_pc, incr_pc;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  npc_next_addr uut (
    .pc_word_i (pc_word),
    .ofs_i     (ofs),
    .jta_i     (jta),
    .rs_val_i  (rs_val),
    .rt_val_i  (rt_val),
    .br_type_i (br_type),
    .pc_src_i  (pc_src),
    .next_pc_o (next_pc),
    .incr_pc_o (incr_pc)
  );

  function automatic logic [29:0] sext(input logic [15:0] o);
    return {{14{o[15]}}, o};
  endfunction

  task automatic check(input string req, input logic [29:0] act, input logic [29:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [29:0] p, input logic [15:0] o, input logic [25:0] j,
                       input logic [31:0] s, input logic [31:0] t,
                       input logic [1:0] b, input logic [1:0] src);
    @(negedge clk);
    pc_word = p; ofs = o; jta = j; rs_val = s; rt_val = t; br_type = b; pc_src = src;
    #1;
  endtask

  task automatic t_reset;
    #1;
    check("R7 reset next", next_pc, 30'd1);
    check("R2 reset incr", incr_pc, 30'd1);
  endtask

  task automatic t_seq;
    apply(30'h0000_1000, 16'h0040, '0, 32'h5, 32'h9, 2'b00, 2'b00);
    check("R2 no-branch incr", incr_pc, 30'h0000_1001);
    check("R7 seq next", next_pc, 30'h0000_1001);
  endtask

  task automatic t_beq;
    apply(30'h0000_1000, 16'h0010, '0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 2'b01, 2'b00);
    check("R3 beq taken", incr_pc, 30'h0000_1000 + 30'd1 + sext(16'h0010));
    check("R6 branch via seq", next_pc, 30'h0000_1011);
    apply(30'h0000_1000, 16'h0010, '0, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 2'b01, 2'b00);
    check("R3 beq not taken", incr_pc, 30'h0000_1001);
  endtask

  task automatic t_bne;
    apply(30'h0000_2000, 16'hFFFC, '0, 32'h1, 32'h2, 2'b10, 2'b00);
    check("R4 bne taken backward", incr_pc, 30'h0000_1FFD);
    apply(30'h0000_2000, 16'hFFFC, '0, 32'h7, 32'h7, 2'b10, 2'b00);
    check("R4 bne not taken", incr_pc, 30'h0000_2001);
  endtask

  task automatic t_bltz;
    apply(30'h0000_0400, 16'h0008, '0, 32'h8000_0000, 32'h8000_0000, 2'b11, 2'b00);
    check("R5 neg taken rt equal", incr_pc, 30'h0000_0409);
    apply(30'h0000_0400, 16'h0008, '0, 32'h7FFF_FFFF, 32'h1234_5678, 2'b11, 2'b00);
    check("R5 positive not taken", incr_pc, 30'h0000_0401);
  endtask

  task automatic t_offsets;
    apply(30'h0001_0000, 16'h8000, '0, 32'h0, 32'h0, 2'b01, 2'b00);
    check("R6 most negative offset", incr_pc, 30'h0001_0000 + 30'd1 - 30'h0000_8000);
    apply(30'h0001_0000, 16'h7FFF, '0, 32'h0, 32'h0, 2'b01, 2'b00);
    check("R6 most positive offset", incr_pc, 30'h0001_8000);
  endtask

  task automatic t_wrap;
    apply(30'h3FFF_FFFF, 16'h0000, '0, 32'h0, 32'h1, 2'b00, 2'b00);
    check("R1 wrap sequential", incr_pc, 30'h0000_0000);
    apply(30'h3FFF_FFFF, 16'h0001, '0, 32'h3, 32'h3, 2'b01, 2'b00);
    check("R1 wrap branch", incr_pc, 30'h0000_0001);
  endtask

  task automatic t_jump;
    apply(30'h2C00_1234, 16'h0000, 26'h155_5555, 32'h0, 32'h0, 2'b00, 2'b01);
    check("R8 jump region", next_pc, {4'hB, 26'h155_5555});
    check("R11 link during jump", incr_pc, 30'h2C00_1235);
  endtask

  task automatic t_jreg;
    apply(30'h0000_0010, 16'h0000, '0, 32'hCAFE_F00F, 32'h0, 2'b00, 2'b10);
    check("R9 register target low bits ignored", next_pc, 30'h32BF_BC03);
    apply(30'h0000_0010, 16'h0000, '0, 32'hCAFE_F00C, 32'h0, 2'b00, 2'b10);
    check("R9 register target aligned", next_pc, 30'h32BF_BC03);
  endtask

  task automatic t_trap;
    apply(30'h1234_5678, 16'h0004, 26'h3FF_FFFF, 32'h9, 32'h9, 2'b01, 2'b11);
    check("R10 trap entry", next_pc, TRAP);
    check("R11 incr under trap select", incr_pc, 30'h1234_567D);
  endtask

  initial begin
    pc_word = '0; ofs = '0; jta = '0; rs_val = '0; rt_val = '0; br_type = '0; pc_src = '0;
    t_reset;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_seq;
    t_beq;
    t_bne;
    t_bltz;
    t_offsets;
    t_wrap;
    t_jump;
    t_jreg;
    t_trap;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule